// File: doc/BRIEF.md
# Shift-Out Sticky Bit Detector

This block decides the sticky bit for a floating-point mantissa register. Given the register value and a right-shift distance N, it reports whether any bit that such a shift would discard is a 1. A rounding stage uses this bit to tell an exact result from an inexact one. The block performs no shift. It only answers whether the discarded part is non-zero.

The detector does not build a mask of the low N bits and reduce it with an OR. Instead it forms the value OR-ed with its own two's-complement negation. That word holds ones from the lowest set bit of the register up to the top and zeros below it. One bit of it, at position N-1, then gives the answer. A second mode ignores N and always looks at a fixed low window of 31 bits, which is the window that single-precision rounding needs. The check reads the register value itself and not any downstream multiplexer. An optional output register, chosen by parameter, places the result one clock after its inputs.

Top module: `stickybit_detect`

## Requirements
- R1: With the single-precision select low and 1 <= N <= 63, the sticky output is 1 exactly when at least one of bits N-1..0 of the mantissa is 1.
- R2: With the single-precision select low and N = 0, the sticky output is 0 for any mantissa.
- R3: With the single-precision select low and N >= 64 (N up to 127), the sticky output is 1 exactly when the mantissa is non-zero.
- R4: A zero mantissa yields a sticky output of 0 for every N and in both modes.
- R5: With the single-precision select high, the sticky output is the OR of mantissa bits 30..0 and the shift amount has no effect.
- R6: With the output register enabled (the default), the output shows the result for the inputs sampled at the previous rising clock edge. While reset (active low) is asserted, the output is 0.
- R7: If the lowest set mantissa bit is at position k, the output is 0 for N = k and 1 for N = k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| mant | input | 64 | Mantissa register value to examine |
| shamt | input | 7 | Right-shift distance N, unsigned |
| sp_sel | input | 1 | 1 selects the fixed 31-bit single-precision window |
| sticky | output | 1 | 1 when a discarded bit is set |

## Verification
The shift-distance test and the single-precision window test can both be requested in the same cycle, because shamt is always present while sp_sel is high. The bench provokes this by driving a shift amount that would give the opposite answer alongside sp_sel. For example, it sets bit 31 only with N = 127, and bit 30 only with N = 0. It then judges that the output follows the 31-bit window alone. It also applies the all-ones-in-reach case (N of 64 or more) together with a zero mantissa, so that the range override and the zero rule meet.

// File: rtl/sticky_pkg.sv
package sticky_pkg;
   typedef enum logic {
      STK_SHIFT  = 1'b0,
      STK_SINGLE = 1'b1
   } stk_mode_e;

   function automatic int unsigned idx_bits(input int unsigned w);
      return (w <= 1) ? 1 : $clog2(w);
   endfunction
endpackage

// File: rtl/sticky_smear.sv
module sticky_smear #(
   parameter int WIDTH = 64
) (
   input  logic [WIDTH-1:0] value,
   output logic [WIDTH-1:0] smear
);
   logic [WIDTH-1:0] neg;

   always_comb begin
      neg   = ~value + {{(WIDTH-1){1'b0}}, 1'b1};
      smear = value | neg;
   end
endmodule

// File: rtl/sticky_select.sv
module sticky_select
   import sticky_pkg::*;
#(
   parameter int WIDTH  = 64,
   parameter int SHW    = 7,
   parameter int SP_WIN = 31
) (
   input  logic [WIDTH-1:0] smear,
   input  logic [SHW-1:0]   shamt,
   input  stk_mode_e        mode,
   output logic             bit_out
);
   localparam int IW = idx_bits(WIDTH);

   logic [SHW-1:0] dec;
   logic [IW-1:0]  idx;
   logic           shift_bit;

   always_comb begin
      dec = shamt - {{(SHW-1){1'b0}}, 1'b1};
      idx = dec[IW-1:0];
      if (shamt == '0)
         shift_bit = 1'b0;
      else if (int'(shamt) >= WIDTH)
         shift_bit = smear[WIDTH-1];
      else
         shift_bit = smear[idx];
   end

   generate
      if (SP_WIN > 0) begin : g_sp
         always_comb bit_out = (mode == STK_SINGLE) ? smear[SP_WIN-1] : shift_bit;
      end else begin : g_nosp
         always_comb bit_out = shift_bit;
      end
   endgenerate
endmodule

// File: rtl/sticky_outreg.sv
module sticky_outreg #(
   parameter bit REG_OUT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) q <= 1'b0;
            else        q <= d;
         end

         p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> q == $past(d));
         p_reset_r6: assert property (@(posedge clk)
            $past(!rst_n) |-> !q);
      end else begin : g_comb
         always_comb q = d;
      end
   endgenerate
endmodule

// File: rtl/stickybit_detect.sv
module stickybit_detect
   import sticky_pkg::*;
#(
   parameter int WIDTH   = 64,
   parameter int SHW     = 7,
   parameter int SP_WIN  = 31,
   parameter bit REG_OUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [63:0]      mant,
   input  logic [6:0]       shamt,
   input  logic             sp_sel,
   output logic             sticky
);
   localparam int IW = idx_bits(WIDTH);

   generate
      if (WIDTH != 64 || SHW != 7) begin : g_bad_port
         $error("stickybit_detect: port widths fixed at 64/7");
      end
      if (SHW < IW) begin : g_bad_shw
         $error("stickybit_detect: SHW cannot reach every bit");
      end
      if (SP_WIN > WIDTH || SP_WIN < 0) begin : g_bad_sp
         $error("stickybit_detect: SP_WIN out of range");
      end
   endgenerate

   logic [WIDTH-1:0] smear;
   logic             raw;
   stk_mode_e        mode;

   always_comb mode = sp_sel ? STK_SINGLE : STK_SHIFT;

   sticky_smear #(.WIDTH(WIDTH)) u_smear (
      .value (mant),
      .smear (smear)
   );

   sticky_select #(.WIDTH(WIDTH), .SHW(SHW), .SP_WIN(SP_WIN)) u_sel (
      .smear   (smear),
      .shamt   (shamt),
      .mode    (mode),
      .bit_out (raw)
   );

   sticky_outreg #(.REG_OUT(REG_OUT)) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw),
      .q     (sticky)
   );

   // reference formulations on the unregistered result
   p_mask_ref_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!sp_sel && shamt != '0 && int'(shamt) < WIDTH) |->
         raw == |(mant & ((64'd1 << shamt) - 64'd1)));
   p_zero_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!sp_sel && shamt == '0) |-> !raw);
   p_far_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!sp_sel && int'(shamt) >= WIDTH) |-> raw == (mant != '0));
   p_zero_mant_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mant == '0) |-> !raw);
   p_single_win_r5: assert property (@(posedge clk) disable iff (!rst_n)
      sp_sel |-> raw == (mant[30:0] != '0));
endmodule

// File: tb/stickybit_detect_test.sv
module stickybit_detect_test;
   localparam int CLK_P = 10;
   localparam int NV    = 15;

   localparam logic [63:0] V_M [NV] = '{
      64'h1, 64'h2, 64'h2, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000,
      64'h8000_0000_0000_0000, 64'h0, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF,
      64'h0000_0000_0010_0000, 64'h0000_0000_0010_0000, 64'h0000_0000_8000_0000,
      64'h0000_0000_4000_0000, 64'hFFFF_FFFF_8000_0000, 64'hFFFF_FFFF_8000_0000};
   localparam logic [6:0] V_N [NV] = '{
      7'd1, 7'd1, 7'd2, 7'd63, 7'd64, 7'd127, 7'd127, 7'd0, 7'd0,
      7'd20, 7'd21, 7'd127, 7'd0, 7'd32, 7'd31};
   localparam logic V_SP [NV] = '{
      1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0,
      1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0};
   localparam logic V_E [NV] = '{
      1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0,
      1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
   localparam string V_R [NV] = '{
      "R1", "R7", "R7", "R7", "R3", "R3", "R4", "R4", "R2",
      "R7", "R1", "R5", "R5", "R1", "R1"};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] mant = '0;
   logic [6:0]  shamt = '0;
   logic        sp_sel = 1'b0;
   logic        sticky;
   int          total = 0;
   int          bad = 0;
   bit          done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   stickybit_detect uut (
      .clk    (clk),
      .rst_n  (rst_n),
      .mant   (mant),
      .shamt  (shamt),
      .sp_sel (sp_sel),
      .sticky (sticky)
   );

   task automatic check(input string req, input logic exp);
      total++;
      if (sticky !== exp) begin
         bad++;
         $display("FAIL %s: sticky=%b expected=%b (mant=%h n=%0d sp=%b)",
                  req, sticky, exp, mant, shamt, sp_sel);
      end
   endtask

   task automatic apply(input logic [63:0] m, input logic [6:0] n, input logic sp);
      @(negedge clk);
      mant = m; shamt = n; sp_sel = sp;
      @(posedge clk);
      #1;
   endtask

   initial begin
      // R6: reset holds output low despite a set discarded bit
      mant = 64'hFFFF_FFFF_FFFF_FFFF; shamt = 7'd64;
      repeat (3) @(posedge clk);
      #1;
      check("R6", 1'b0);
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         apply(V_M[i], V_N[i], V_SP[i]);
         check(V_R[i], V_E[i]);
      end

      // R6: one-cycle latency
      apply(64'h0, 7'd5, 1'b0);
      check("R6", 1'b0);
      @(negedge clk);
      mant = 64'h10; shamt = 7'd5; sp_sel = 1'b0;
      #1;
      check("R6", 1'b0);
      @(posedge clk);
      #1;
      check("R6", 1'b1);

      // R5: window ignores shift amount in both directions
      apply(64'hFFFF_FFFF_8000_0000, 7'd64, 1'b1);
      check("R5", 1'b0);
      apply(64'h0000_0000_0000_0001, 7'd0, 1'b1);
      check("R5", 1'b1);

      // R7: sweep lowest-set-bit boundary
      for (int k = 0; k < 63; k += 9) begin
         apply(64'd1 << k, 7'(k), 1'b0);
         check("R7", 1'b0);
         apply(64'd1 << k, 7'(k + 1), 1'b0);
         check("R7", 1'b1);
      end

      // R6: reset in mid-run clears output
      @(negedge clk);
      rst_n = 1'b0; mant = 64'h1; shamt = 7'd1;
      @(posedge clk);
      #1;
      check("R6", 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      check("R1", 1'b1);

      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            total++;
            bad++;
            $display("FAIL watchdog: done=0 expected=1");
         end
      join_any
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule